// File: doc/BRIEF.md
# Programmable Frequency Output Selector

This block turns a free-running timekeeping clock into a square wave at one of fifteen selectable rates, from 32768 Hz down to 1/32 Hz, or into no wave at all. The wave leaves the block as a pull-low enable for an open-drain pin. When the enable is 0 the pin is released, and the board pull-up reads as logic 1. When the enable is 1 the pin is pulled low.

The block's clock `clk` runs at twice the base rate, 65536 Hz. This lets the 32768 Hz setting be a registered divide-by-two, like every other rate. All rates are taps of one shared binary counter, so every wave has a 50% duty cycle.

A new rate is taken up only while both the present wave and the requested wave are low, so no short high pulse can appear. A battery-gating bit decides whether the wave keeps running while the device is on backup supply. A separate flag tells the alarm logic to stand down whenever a nonzero rate is requested.

The switch controller has three states:
- `ST_OFF`: pin released.
- `ST_RUN`: the wave follows the adopted code.
- `ST_HOLD`: a different code is requested and is waiting for a common low phase.

Its transitions are:
- **arm** (`ST_OFF`→`ST_RUN`): a nonzero code is requested and its wave is low.
- **wait-arm** (`ST_OFF`→`ST_OFF`): a nonzero code is requested but its wave is high.
- **defer** (`ST_RUN`→`ST_HOLD`): the code differs and the low-phase condition is not met.
- **swap** (`ST_RUN`/`ST_HOLD`→`ST_RUN`): a nonzero code is adopted.
- **stop** (`ST_RUN`/`ST_HOLD`→`ST_OFF`): code 0 is adopted.
- **revert** (`ST_HOLD`→`ST_RUN`): the request returns to the adopted code.

Top module: `freq_out_sel`

## Requirements
- R1: While reset is asserted and on the first cycle after reset, `pin_drive_low` is 0 and `alarm_block` is 0 when `rate_sel` is 0.
- R2: While `rate_sel` is 0 and the previous wave has finished its high phase, `pin_drive_low` stays 0 on every cycle.
- R3: Code c selects counter bit e, and the wave is low while that bit is 0. The mapping is 1→0, 2→3, 3→5, and c→c+5 for c from 4 to 15. Each phase therefore lasts 2^e `clk` cycles, giving 32768/2^e Hz. The counter starts at 0 on reset, so code 15 stays low for the first 2^20 cycles.
- R4: For every nonzero code the low phase and the high phase are the same length.
- R5: A new code is adopted only in a cycle where both the present wave and the requested wave are low. No high phase is ever shorter than the shorter of the two half periods.
- R6: When `bat_gate` is 1 and `on_backup` is 1, `pin_drive_low` is 0 in that same cycle. When `on_backup` returns to 0, the wave resumes at once.
- R7: When `bat_gate` is 0, the wave keeps running unchanged while `on_backup` is 1.
- R8: `alarm_block` is 1 exactly when `rate_sel` is nonzero, regardless of battery gating and of pending switches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timekeeping clock at 65536 Hz |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 4 | Requested rate code; 0 turns the output off |
| bat_gate | input | 1 | 1 = release the pin while on backup supply |
| on_backup | input | 1 | 1 = device currently runs from backup supply |
| pin_drive_low | output | 1 | 1 = pull the open-drain pin low; 0 = released |
| alarm_block | output | 1 | 1 = frequency output requested, alarm must stay off |

## Verification
Battery gating and a pending rate switch can fall in the same cycle. Gating acts on the pin at once, while the switch waits in `ST_HOLD` for a common low phase of the ungated waves. The bench provokes this by requesting a new code and raising `on_backup` with `bat_gate` set on the same edge. It then judges that the pin stays released for the whole backup window. After backup ends, it measures full low and high phases at the new rate, which shows the switch completed unseen and without a runt pulse.

// File: rtl/fo_pkg.sv
package fo_pkg;

    localparam int unsigned FO_SEL_W   = 4;
    localparam int unsigned FO_TOP_EXP = 20;
    localparam int unsigned FO_CNT_W   = FO_TOP_EXP + 1;
    localparam int unsigned FO_NCODE   = 1 << FO_SEL_W;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } fo_state_e;

    // Counter bit that carries the wave for a given code (code 0 unused).
    function automatic int unsigned fo_exp(input logic [FO_SEL_W-1:0] code);
        case (code)
            4'd1:    return 0;
            4'd2:    return 3;
            4'd3:    return 5;
            default: return int'(code) + 5;
        endcase
    endfunction

endpackage

// File: rtl/fo_divider.sv
module fo_divider
    import fo_pkg::*;
#(
    parameter int unsigned CNT_W = FO_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt = cnt_q;

    // R3
    div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/fo_rate_mux.sv
module fo_rate_mux
    import fo_pkg::*;
#(
    parameter int unsigned CNT_W = FO_CNT_W
) (
    input  logic [CNT_W-1:0]    cnt,
    input  logic [FO_SEL_W-1:0] code,
    output logic                tap
);

    logic [FO_NCODE-1:0] taps;
    logic                unused_cnt_bits;

    assign taps[0] = 1'b0;

    for (genvar g = 1; g < FO_NCODE; g++) begin : g_tap
        assign taps[g] = cnt[fo_exp(FO_SEL_W'(g))];
    end

    assign tap             = taps[code];
    assign unused_cnt_bits = ^cnt;

endmodule

// File: rtl/fo_switch_fsm.sv
module fo_switch_fsm
    import fo_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FO_SEL_W-1:0] req_code,
    input  logic                req_tap,
    input  logic                cur_tap,
    output logic [FO_SEL_W-1:0] cur_code,
    output logic                wave_lo
);

    fo_state_e           state_q, state_d;
    logic [FO_SEL_W-1:0] cur_q, cur_d;
    logic                both_low;

    assign both_low = !cur_tap && !req_tap;

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        unique case (state_q)
            ST_OFF: begin
                if (req_code != '0 && !req_tap) begin
                    state_d = ST_RUN;
                    cur_d   = req_code;
                end
            end
            ST_RUN, ST_HOLD: begin
                if (req_code == cur_q) begin
                    state_d = ST_RUN;
                end else if (both_low) begin
                    cur_d   = req_code;
                    state_d = (req_code == '0) ? ST_OFF : ST_RUN;
                end else begin
                    state_d = ST_HOLD;
                end
            end
            default: begin
                state_d = ST_OFF;
                cur_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    always_comb begin
        cur_code = cur_q;
        wave_lo  = (state_q != ST_OFF) && !cur_tap;
    end

    // R5
    switch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q) |-> ($past(cur_tap) == 1'b0 && $past(req_tap) == 1'b0));

    // R2
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && req_code == '0) |=> state_q == ST_OFF);

endmodule

// File: rtl/freq_out_sel.sv
module freq_out_sel
    import fo_pkg::*;
#(
    parameter int unsigned CNT_W = FO_CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FO_SEL_W-1:0] rate_sel,
    input  logic                bat_gate,
    input  logic                on_backup,
    output logic                pin_drive_low,
    output logic                alarm_block
);

    logic [CNT_W-1:0]    cnt;
    logic [FO_SEL_W-1:0] cur_code;
    logic                cur_tap;
    logic                req_tap;
    logic                wave_lo;
    logic                gated;

    fo_divider #(.CNT_W(CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt)
    );

    fo_rate_mux #(.CNT_W(CNT_W)) u_cur_mux (
        .cnt  (cnt),
        .code (cur_code),
        .tap  (cur_tap)
    );

    fo_rate_mux #(.CNT_W(CNT_W)) u_req_mux (
        .cnt  (cnt),
        .code (rate_sel),
        .tap  (req_tap)
    );

    fo_switch_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_code (rate_sel),
        .req_tap  (req_tap),
        .cur_tap  (cur_tap),
        .cur_code (cur_code),
        .wave_lo  (wave_lo)
    );

    assign gated         = bat_gate && on_backup;
    assign pin_drive_low = wave_lo && !gated;
    assign alarm_block   = (rate_sel != '0);

    // R6
    gate_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bat_gate && on_backup) |-> !pin_drive_low);

endmodule

// File: tb/tb_freq_out_sel.sv
module tb_freq_out_sel;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] rate_sel;
    logic       bat_gate;
    logic       on_backup;
    logic       pin_drive_low;
    logic       alarm_block;

    always #2 clk = ~clk;

    freq_out_sel dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rate_sel      (rate_sel),
        .bat_gate      (bat_gate),
        .on_backup     (on_backup),
        .pin_drive_low (pin_drive_low),
        .alarm_block   (alarm_block)
    );

    int errs   = 0;
    int checks = 0;
    bit done   = 1'b0;

    localparam int NV = 8;
    localparam logic [3:0] V_CODE [NV] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8};
    localparam int         V_HALF [NV] = '{1, 8, 32, 512, 1024, 2048, 4096, 8192};

    function automatic logic lvl();
        return !pin_drive_low;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(output int lo_len, output int hi_len);
        int guard = 0;
        while (!lvl() && guard < 70000) begin tick(1); guard++; end
        while (lvl() && guard < 70000)  begin tick(1); guard++; end
        lo_len = 0;
        while (!lvl() && guard < 70000) begin lo_len++; tick(1); guard++; end
        hi_len = 0;
        while (lvl() && guard < 70000)  begin hi_len++; tick(1); guard++; end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int lo, hi;
        rst_n     = 1'b0;
        rate_sel  = 4'd0;
        bat_gate  = 1'b0;
        on_backup = 1'b0;
        tick(3);
        // R1: reset state
        check(pin_drive_low == 1'b0, "R1 pin released in reset", int'(pin_drive_low), 0);
        rst_n = 1'b1;
        tick(1);
        check(pin_drive_low == 1'b0, "R1 pin released after reset", int'(pin_drive_low), 0);
        check(alarm_block == 1'b0, "R1 alarm_block idle", int'(alarm_block), 0);

        // Vector table: R3 rate and R4 duty for codes 1..8
        for (int i = 0; i < NV; i++) begin
            rate_sel = V_CODE[i];
            tick(2 * V_HALF[i] + 2);
            check(alarm_block == 1'b1, "R8 alarm_block with nonzero code", int'(alarm_block), 1);
            measure(lo, hi);
            check(lo == V_HALF[i], "R3 low phase length", lo, V_HALF[i]);
            check(hi == V_HALF[i], "R4 high phase length", hi, V_HALF[i]);
        end

        // R5: switch 5 -> 4 with no short high phase
        rate_sel = 4'd5;
        tick(2 * 8192 + 4);
        measure(lo, hi);
        check(hi == 1024, "R3 code 5 settled", hi, 1024);
        begin
            int   run    = 0;
            int   min_hi = 1 << 30;
            bit   inrun  = 1'b0;
            logic prev;
            prev     = lvl();
            rate_sel = 4'd4;
            for (int k = 0; k < 6000; k++) begin
                logic cur;
                cur = lvl();
                if (cur && !prev) begin
                    inrun = 1'b1;
                    run   = 1;
                end else if (cur && inrun) begin
                    run++;
                end else if (!cur && prev && inrun) begin
                    if (run < min_hi) min_hi = run;
                    inrun = 1'b0;
                end
                prev = cur;
                tick(1);
            end
            check(min_hi >= 512 && min_hi < (1 << 30), "R5 shortest high phase across switch", min_hi, 512);
        end
        measure(lo, hi);
        check(lo == 512 && hi == 512, "R5 new rate after switch", hi, 512);

        // R6: gating onset in the same cycle as a pending switch
        rate_sel  = 4'd5;
        bat_gate  = 1'b1;
        on_backup = 1'b1;
        #1;
        check(pin_drive_low == 1'b0, "R6 released in gating cycle", int'(pin_drive_low), 0);
        check(alarm_block == 1'b1, "R8 alarm_block while gated", int'(alarm_block), 1);
        begin
            int viol = 0;
            for (int k = 0; k < 3000; k++) begin
                tick(1);
                if (pin_drive_low) viol++;
            end
            check(viol == 0, "R6 cycles driven while gated", viol, 0);
        end
        on_backup = 1'b0;
        tick(4);
        measure(lo, hi);
        check(lo == 1024 && hi == 1024, "R6 rate resumes after backup", lo, 1024);

        // R7: no gating, wave runs on backup
        bat_gate  = 1'b0;
        on_backup = 1'b1;
        measure(lo, hi);
        check(lo == 1024, "R7 low phase on backup", lo, 1024);
        check(hi == 1024, "R7 high phase on backup", hi, 1024);
        on_backup = 1'b0;

        // R2: code 0 releases the pin
        rate_sel = 4'd0;
        #1;
        check(alarm_block == 1'b0, "R8 alarm_block clears for code 0", int'(alarm_block), 0);
        tick(2048 + 2);
        begin
            int viol = 0;
            for (int k = 0; k < 3000; k++) begin
                if (pin_drive_low) viol++;
                tick(1);
            end
            check(viol == 0, "R2 cycles driven with code 0", viol, 0);
        end

        // R3: slowest code holds low early after reset
        rate_sel = 4'd15;
        tick(2);
        begin
            int rel = 0;
            for (int k = 0; k < 5000; k++) begin
                if (!pin_drive_low) rel++;
                tick(1);
            end
            check(rel == 0, "R3 code 15 low phase cycles released", rel, 0);
        end
        bat_gate  = 1'b1;
        on_backup = 1'b1;
        #1;
        check(pin_drive_low == 1'b0, "R6 gate releases slow wave", int'(pin_drive_low), 0);
        on_backup = 1'b0;
        #1;
        check(pin_drive_low == 1'b1, "R6 wave back when backup ends", int'(pin_drive_low), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule